// File: doc/BRIEF.md
# DDR2 Write Data Prefetch Gearbox

This block sits on the write path between a memory controller's data capture and the array core of a DDR2-style memory. The controller side delivers write data as double-rate beats that have already been sampled: a rising-edge lane and a falling-edge lane per clock, each carrying one n-bit beat and its per-byte mask bits. The gearbox collects four consecutive beats (two clocks) into a single 4n-bit prefetch word. It then presents that word to the core as one write strobe, together with a column address whose two low bits are zero.

A write command carries a start column and a burst-length select: four or eight locations. Data for a command arrives a write latency after the command, and the write latency is always one clock less than the programmed read latency, which is an input. A burst of eight produces two core words with columns four apart. A later write command may cut a burst of eight short. Whatever part of the old burst has not yet formed a complete group is then discarded, and gathering starts again for the new burst.

Top module: `ddr_wr_gearbox`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `core_we` is 0, and `core_col`, `core_data` and `core_mask` are 0.
- R2: In `core_data`, the field at bits [k*DW +: DW] holds beat k of the group. Beat 0 is the rising lane of the group's first data clock, beat 1 is that clock's falling lane, beat 2 is the rising lane of the second data clock, and beat 3 is its falling lane.
- R3: `core_mask` carries the mask of beat k unaltered at bits [k*MW +: MW], where MW = DW/8. Within a beat, mask bit j covers data byte j (bit 0 covers data bits 7:0 and bit 1 covers bits 15:8), and a 1 means that byte is not written.
- R4: The first data clock of a command comes WL = `rd_lat` - 1 clocks after the clock on which `cmd_wr` is sampled high, for `rd_lat` from 2 to MAX_RL.
- R5: `core_we` is high for exactly the one clock following the edge at which a group's second data clock is sampled, and it is never high on two consecutive clocks.
- R6: A burst of four (`cmd_bl8` = 0) yields one core write at column `cmd_col` with its two low bits cleared.
- R7: A burst of eight (`cmd_bl8` = 1) yields two core writes two clocks apart. The second column equals the first plus 4, modulo 2^COL_W.
- R8: Commands issued two clocks apart give gapless data and core writes two clocks apart, each with its own column and data.
- R9: When a new command's data begins before the current burst has completed its group, the incomplete group is dropped without a core write, and the new burst is gathered from its first beat.
- R10: Lane contents on clocks that belong to no burst are ignored, and no core write occurs then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write command this clock |
| cmd_col | input | COL_W | Start column of the write |
| cmd_bl8 | input | 1 | 1 = burst of eight, 0 = burst of four |
| rd_lat | input | LAT_W | Programmed read latency in clocks (2..MAX_RL) |
| beat_rise | input | DW | Beat captured on the rising strobe edge |
| beat_fall | input | DW | Beat captured on the falling strobe edge |
| mask_rise | input | MW | Byte masks for the rising-edge beat |
| mask_fall | input | MW | Byte masks for the falling-edge beat |
| core_we | output | 1 | Core write strobe, one clock per prefetch word |
| core_col | output | COL_W | Aligned column of the core word |
| core_data | output | 4*DW | Four packed beats |
| core_mask | output | 4*MW | Four packed byte masks |

## Verification
The gearbox is driven with isolated bursts of four and of eight at three read latencies (2, 4 and 8), plus a fourth at 5. This separates a correct latency tap from an off-by-one, and it shows that the second group's column is stepped by four, including wrap-around at the top of the column space. Commands two clocks apart distinguish seamless gathering from a design that needs idle clocks. Interrupts at two and at three clocks separate a cleanly cut burst from one where half a group has already been captured, and each must yield no stray write. Every beat and mask value is distinct per seed and per lane position, and idle clocks carry filler data. A swapped lane, a mis-ordered beat or a captured filler therefore shows up as a data mismatch, and any unexpected strobe fails the per-clock quiet check.

// File: rtl/ddr_wr_gearbox_pkg.sv
package ddr_wr_gearbox_pkg;

  // Gathering phase: idle, expecting the low half (beats 0,1), expecting the high half (beats 2,3)
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_LOW  = 2'd1,
    GS_HIGH = 2'd2
  } gather_state_e;

  // Delay-line tap for a read latency: write latency minus one, latency clamped to 2..max_rl
  function automatic int unsigned lat_to_tap(int unsigned rl, int unsigned max_rl);
    int unsigned r;
    r = rl;
    if (r < 2) r = 2;
    if (r > max_rl) r = max_rl;
    return r - 2;
  endfunction

  // Core column of a prefetch group: start column aligned to four, stepped by four for the second group
  function automatic int unsigned group_col(int unsigned start_col, logic second);
    return (start_col & 32'hFFFF_FFFC) + (second ? 32'd4 : 32'd0);
  endfunction

endpackage

// File: rtl/ddr_wr_cmd_delay.sv
module ddr_wr_cmd_delay
  import ddr_wr_gearbox_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MAX_RL = 8,
  parameter int LAT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_bl8,
  input  logic [LAT_W-1:0] rd_lat,
  output logic             arr_vld,
  output logic [COL_W-1:0] arr_col,
  output logic             arr_bl8
);

  localparam int DEPTH = (MAX_RL > 2) ? MAX_RL - 1 : 1;

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] bl8_q;
  logic [COL_W-1:0] col_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[0] <= 1'b0;
          bl8_q[0] <= 1'b0;
          col_q[0] <= '0;
        end else begin
          vld_q[0] <= cmd_wr;
          bl8_q[0] <= cmd_bl8;
          col_q[0] <= cmd_col;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          bl8_q[g] <= 1'b0;
          col_q[g] <= '0;
        end else begin
          vld_q[g] <= vld_q[g-1];
          bl8_q[g] <= bl8_q[g-1];
          col_q[g] <= col_q[g-1];
        end
      end
    end
  end

  int unsigned tap;
  assign tap = lat_to_tap(32'(rd_lat), 32'(MAX_RL));

  always_comb begin
    arr_vld = 1'b0;
    arr_bl8 = 1'b0;
    arr_col = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (tap == 32'(i)) begin
        arr_vld = vld_q[i];
        arr_bl8 = bl8_q[i];
        arr_col = col_q[i];
      end
    end
  end

endmodule

// File: rtl/ddr_wr_gather.sv
module ddr_wr_gather
  import ddr_wr_gearbox_pkg::*;
#(
  parameter int DW    = 16,
  parameter int MW    = 2,
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_vld,
  input  logic [COL_W-1:0]  arr_col,
  input  logic              arr_bl8,
  input  logic [DW-1:0]     beat_rise,
  input  logic [DW-1:0]     beat_fall,
  input  logic [MW-1:0]     mask_rise,
  input  logic [MW-1:0]     mask_fall,
  output logic              core_we,
  output logic [COL_W-1:0]  core_col,
  output logic [4*DW-1:0]   core_data,
  output logic [4*MW-1:0]   core_mask,
  output logic              evt_second
);

  gather_state_e     state_q;
  logic              second_q;
  logic              bl8_q;
  logic [COL_W-1:0]  start_col_q;
  logic [2*DW-1:0]   lo_data_q;
  logic [2*MW-1:0]   lo_mask_q;

  logic cap_hi;
  assign cap_hi = !arr_vld && (state_q == GS_HIGH);

  // Phase tracking; an arriving burst always restarts gathering
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= GS_IDLE;
      second_q    <= 1'b0;
      bl8_q       <= 1'b0;
      start_col_q <= '0;
      lo_data_q   <= '0;
      lo_mask_q   <= '0;
    end else if (arr_vld) begin
      state_q     <= GS_HIGH;
      second_q    <= 1'b0;
      bl8_q       <= arr_bl8;
      start_col_q <= arr_col;
      lo_data_q   <= {beat_fall, beat_rise};
      lo_mask_q   <= {mask_fall, mask_rise};
    end else begin
      case (state_q)
        GS_LOW: begin
          lo_data_q <= {beat_fall, beat_rise};
          lo_mask_q <= {mask_fall, mask_rise};
          state_q   <= GS_HIGH;
        end
        GS_HIGH: begin
          state_q  <= (bl8_q && !second_q) ? GS_LOW : GS_IDLE;
          second_q <= 1'b1;
        end
        default: state_q <= GS_IDLE;
      endcase
    end
  end

  // Registered core word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_we    <= 1'b0;
      core_col   <= '0;
      core_data  <= '0;
      core_mask  <= '0;
      evt_second <= 1'b0;
    end else begin
      core_we    <= cap_hi;
      evt_second <= cap_hi && second_q;
      if (cap_hi) begin
        core_data <= {beat_fall, beat_rise, lo_data_q};
        core_mask <= {mask_fall, mask_rise, lo_mask_q};
        core_col  <= COL_W'(group_col(32'(start_col_q), second_q));
      end
    end
  end

endmodule

// File: rtl/ddr_wr_gearbox.sv
module ddr_wr_gearbox
  import ddr_wr_gearbox_pkg::*;
#(
  parameter  int DW     = 16,
  parameter  int COL_W  = 10,
  parameter  int MAX_RL = 8,
  localparam int MW     = DW / 8,
  localparam int LAT_W  = $clog2(MAX_RL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_bl8,
  input  logic [LAT_W-1:0] rd_lat,
  input  logic [DW-1:0]    beat_rise,
  input  logic [DW-1:0]    beat_fall,
  input  logic [MW-1:0]    mask_rise,
  input  logic [MW-1:0]    mask_fall,
  output logic             core_we,
  output logic [COL_W-1:0] core_col,
  output logic [4*DW-1:0]  core_data,
  output logic [4*MW-1:0]  core_mask
);

  // Named events for the checker
  logic             arr_vld;
  logic [COL_W-1:0] arr_col;
  logic             arr_bl8;
  logic             evt_second;

  ddr_wr_cmd_delay #(
    .COL_W (COL_W),
    .MAX_RL(MAX_RL),
    .LAT_W (LAT_W)
  ) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_wr (cmd_wr),
    .cmd_col(cmd_col),
    .cmd_bl8(cmd_bl8),
    .rd_lat (rd_lat),
    .arr_vld(arr_vld),
    .arr_col(arr_col),
    .arr_bl8(arr_bl8)
  );

  ddr_wr_gather #(
    .DW   (DW),
    .MW   (MW),
    .COL_W(COL_W)
  ) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_vld   (arr_vld),
    .arr_col   (arr_col),
    .arr_bl8   (arr_bl8),
    .beat_rise (beat_rise),
    .beat_fall (beat_fall),
    .mask_rise (mask_rise),
    .mask_fall (mask_fall),
    .core_we   (core_we),
    .core_col  (core_col),
    .core_data (core_data),
    .core_mask (core_mask),
    .evt_second(evt_second)
  );

endmodule

// File: rtl/ddr_wr_gearbox_chk.sv
module ddr_wr_gearbox_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arr_vld,
  input logic             evt_second,
  input logic             core_we,
  input logic [COL_W-1:0] core_col
);

  // R1: reset keeps the strobe low on the following clock
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !core_we);

  // R5: one-clock strobe, never back to back
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |=> !core_we);

  // R6: every core word is four-aligned
  assert_aligned_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |-> (core_col[1:0] == 2'b00));

  // R7: second group follows the first two clocks later, column plus four
  assert_second_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && evt_second) |-> ($past(core_we, 2) &&
      (core_col == COL_W'($past(core_col, 2) + COL_W'(4)))));

  // R9: a restart never completes a group on the next clock
  assert_restart_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_vld |=> !core_we);

endmodule

bind ddr_wr_gearbox ddr_wr_gearbox_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arr_vld   (arr_vld),
  .evt_second(evt_second),
  .core_we   (core_we),
  .core_col  (core_col)
);

// File: tb/tb_ddr_wr_gearbox.sv
`timescale 1ns/1ps
module tb_ddr_wr_gearbox;

  localparam int DW    = 16;
  localparam int MW    = 2;
  localparam int COL_W = 10;
  localparam int NCYC  = 600;
  localparam int LAST  = 560;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_wr;
  logic [COL_W-1:0] cmd_col;
  logic             cmd_bl8;
  logic [3:0]       rd_lat;
  logic [DW-1:0]    beat_rise, beat_fall;
  logic [MW-1:0]    mask_rise, mask_fall;
  logic             core_we;
  logic [COL_W-1:0] core_col;
  logic [4*DW-1:0]  core_data;
  logic [4*MW-1:0]  core_mask;

  ddr_wr_gearbox dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_col(cmd_col), .cmd_bl8(cmd_bl8),
    .rd_lat(rd_lat), .beat_rise(beat_rise), .beat_fall(beat_fall),
    .mask_rise(mask_rise), .mask_fall(mask_fall), .core_we(core_we),
    .core_col(core_col), .core_data(core_data), .core_mask(core_mask)
  );

  always #2.5 clk = ~clk;

  // Per-cycle stimulus plan
  logic             cmd_a  [NCYC];
  logic [COL_W-1:0] col_a  [NCYC];
  logic             bl8_a  [NCYC];
  logic [3:0]       lat_a  [NCYC];
  logic [DW-1:0]    rise_a [NCYC];
  logic [DW-1:0]    fall_a [NCYC];
  logic [MW-1:0]    mr_a   [NCYC];
  logic [MW-1:0]    mf_a   [NCYC];

  typedef struct packed {
    int               cyc;
    logic [COL_W-1:0] col;
    logic [4*DW-1:0]  data;
    logic [4*MW-1:0]  mask;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] beat_val(int seed, int i);
    return DW'((seed * 4969) ^ (i * 9029) ^ 16'h3C00 ^ (seed << 12));
  endfunction

  function automatic logic [MW-1:0] mask_val(int seed, int i);
    return MW'((seed + i) % 4);
  endfunction

  // Driver-side scheduler: places command and beats, pushes expected core words
  task automatic sched(int c, int col, bit bl8, int seed, int keep, int lat, string tag);
    int wl;
    int ngrp;
    wl = lat - 1;
    ngrp = bl8 ? 2 : 1;
    cmd_a[c] = 1'b1;
    col_a[c] = COL_W'(col);
    bl8_a[c] = bl8;
    for (int g = 0; g < ngrp; g++) begin
      int d0;
      exp_t e;
      d0 = c + wl + 2 * g;
      rise_a[d0]   = beat_val(seed, 4 * g);
      fall_a[d0]   = beat_val(seed, 4 * g + 1);
      mr_a[d0]     = mask_val(seed, 4 * g);
      mf_a[d0]     = mask_val(seed, 4 * g + 1);
      rise_a[d0+1] = beat_val(seed, 4 * g + 2);
      fall_a[d0+1] = beat_val(seed, 4 * g + 3);
      mr_a[d0+1]   = mask_val(seed, 4 * g + 2);
      mf_a[d0+1]   = mask_val(seed, 4 * g + 3);
      if (g < keep) begin
        e.cyc  = d0 + 2;
        e.col  = COL_W'((col - (col % 4) + 4 * g) % (1 << COL_W));
        e.data = {beat_val(seed, 4*g+3), beat_val(seed, 4*g+2),
                  beat_val(seed, 4*g+1), beat_val(seed, 4*g)};
        e.mask = {mask_val(seed, 4*g+3), mask_val(seed, 4*g+2),
                  mask_val(seed, 4*g+1), mask_val(seed, 4*g)};
        exp_q.push_back(e);
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, expv);
    end
  endtask

  // Cycle counter
  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Plan and driver
  initial begin
    for (int k = 0; k < NCYC; k++) begin
      cmd_a[k]  = 1'b0;
      col_a[k]  = COL_W'(k * 7);
      bl8_a[k]  = k[0];
      lat_a[k]  = 4'd4;
      rise_a[k] = DW'(k * 40503) ^ 16'hA5A5;
      fall_a[k] = DW'(k * 27011) ^ 16'h5A5A;
      mr_a[k]   = MW'(k);
      mf_a[k]   = MW'(k + 1);
    end
    for (int k = 160; k < 270; k++) lat_a[k] = 4'd2;
    for (int k = 270; k < 410; k++) lat_a[k] = 4'd8;
    for (int k = 410; k < NCYC; k++) lat_a[k] = 4'd5;

    // latency 4: basic bursts, seamless, interrupts, wrap
    sched(10, 'h013, 1'b0, 1, 1, 4, "R2 R3 R4 R6");
    sched(20, 'h026, 1'b1, 2, 2, 4, "R2 R7");
    sched(40, 'h100, 1'b0, 3, 1, 4, "R8");
    sched(42, 'h104, 1'b0, 4, 1, 4, "R8");
    sched(60, 'h040, 1'b1, 5, 1, 4, "R9 clean cut");
    sched(62, 'h080, 1'b0, 6, 1, 4, "R9 new burst");
    sched(80, 'h0C8, 1'b1, 7, 1, 4, "R9 partial");
    sched(83, 'h1F0, 1'b1, 8, 2, 4, "R9 restart");
    sched(100, 'h3FE, 1'b1, 9, 2, 4, "R7 wrap");
    // latency 2
    sched(170, 'h155, 1'b1, 10, 2, 2, "R4 R7 lat2");
    sched(190, 'h2A2, 1'b0, 11, 1, 2, "R4 R6 lat2");
    // latency 8
    sched(280, 'h007, 1'b0, 12, 1, 8, "R4 lat8");
    sched(300, 'h210, 1'b1, 13, 2, 8, "R4 R7 lat8");
    // latency 5: interrupt of burst eight by burst eight
    sched(420, 'h300, 1'b1, 14, 1, 5, "R9 lat5");
    sched(422, 'h308, 1'b1, 15, 2, 5, "R9 R7 lat5");

    rst_n = 1'b0; cmd_wr = 1'b0; cmd_col = '0; cmd_bl8 = 1'b0; rd_lat = 4'd4;
    beat_rise = '0; beat_fall = '0; mask_rise = '0; mask_fall = '0;
    forever begin
      @(negedge clk);
      if (cyc < NCYC) begin
        rst_n     = (cyc >= 4);
        cmd_wr    = cmd_a[cyc];
        cmd_col   = col_a[cyc];
        cmd_bl8   = bl8_a[cyc];
        rd_lat    = lat_a[cyc];
        beat_rise = rise_a[cyc];
        beat_fall = fall_a[cyc];
        mask_rise = mr_a[cyc];
        mask_fall = mf_a[cyc];
      end
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (cyc == 3) begin
        check(core_we == 1'b0, "R1", "strobe in reset", 64'(core_we), 64'd0);
        check(core_col == '0, "R1", "column in reset", 64'(core_col), 64'd0);
        check(core_data == '0, "R1", "data in reset", core_data, 64'd0);
        check(core_mask == '0, "R1", "mask in reset", 64'(core_mask), 64'd0);
      end else if (cyc >= 5 && cyc <= LAST) begin
        bit exp_we;
        exp_we = (exp_q.size() > 0) && (exp_q[0].cyc == cyc);
        if (exp_we) begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(core_we == 1'b1, t, "strobe", 64'(core_we), 64'd1);
          if (core_we) begin
            check(core_col == e.col, t, "column", 64'(core_col), 64'(e.col));
            check(core_data == e.data, t, "data", core_data, e.data);
            check(core_mask == e.mask, t, "mask", 64'(core_mask), 64'(e.mask));
          end
        end else begin
          check(core_we == 1'b0, "R10 R5 R9", "unexpected strobe", 64'(core_we), 64'd0);
        end
      end
      if (cyc == LAST + 1) begin
        check(exp_q.size() == 0, "R4", "outstanding core words", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion by cycle %0d", LAST + 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule